// File: doc/BRIEF.md
# Variable-Rate Sample Request Pacer

This block sits beside an audio link whose frames always arrive at a fixed 48 kHz. Each converter has its own programmed sample rate: the front, rear and low-frequency DAC pairs, and the ADC, whose left and right channels share one rate. Once per frame the block decides for each converter whether a sample moves in that frame. For each DAC pair this decision is a request to the controller. For the ADC it is a valid flag on the outgoing sample. Over time the decisions add up to exactly the programmed rate.

Each converter has a phase accumulator. On every frame strobe the programmed rate is added to it. When the sum reaches 48000, 48000 is taken off and the converter fires. The rate registers accept any 16-bit value and store the nearest supported rate. A read returns the stored value. Once a DAC pair has issued a request, the controller must supply the sample with the next frame. If it does not, the block pulses an underrun flag.

Top module: `vrate_requester`

## Requirements
- R1: After reset, all four rate registers read 48000 (16'hBB80).
- R2: The registers sit at 7-bit addresses 7'h2C (front), 7'h2E (rear), 7'h30 (low-frequency) and 7'h32 (ADC). rd_data_o shows the register that addr_i selects and has no clock delay. Any other address reads 0, and a write to it changes no register.
- R3: A write stores the supported rate (8000, 11025, 16000, 22050, 32000, 44100, 48000) with the smallest absolute difference from wr_data_i. An exact tie goes to the lower rate, and every value above 48000 becomes 48000.
- R4: On a cycle with frame_i high, each enabled converter adds its rate to a phase that starts at 0. If the sum is 48000 or more, the converter fires and keeps the sum minus 48000. Otherwise it keeps the sum. The firing shows as a one-cycle pulse on req_o (bit 0 front, bit 1 rear, bit 2 low-frequency) in the cycle after the strobe.
- R5: Starting from phase 0, a rate of 44100 gives exactly 441 front requests in 480 frames.
- R6: adc_valid_o follows the R4 rule using the ADC register. Starting from phase 0, a rate of 8000 gives exactly 80 valid pulses in 480 frames.
- R7: The low-frequency channel is enabled only while mode_i is 2'b10 and id_i is 2'b11. While it is disabled, address 7'h30 reads 0 and ignores writes, req_o[2] stays low, and its phase and pending request are cleared.
- R8: Suppose a DAC pair fired on one strobe, and its data_i bit is low on the next strobe. Then underrun_o for that pair pulses in the cycle after that next strobe, in the same cycle as any new request from the pair.
- R9: A write on a strobe cycle takes effect from the following strobe. The strobe in the write cycle uses the old rate.
- R10: req_o, adc_valid_o and underrun_o are never high except in the cycle after a frame_i strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | One-cycle strobe per 48 kHz frame |
| mode_i | input | 2 | Operating mode |
| id_i | input | 2 | Codec identity |
| data_i | input | 3 | Sample present in this frame, per DAC pair |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 7 | Register address for write and read |
| wr_data_i | input | 16 | Requested rate in samples per second |
| rd_data_o | output | 16 | Stored rate at addr_i |
| req_o | output | 3 | Per-DAC-pair sample request pulse |
| adc_valid_o | output | 1 | ADC sample valid pulse |
| underrun_o | output | 3 | Per-DAC-pair missing-sample pulse |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a register write and a frame strobe. The bench drives both in one cycle and expects the pacing from the old rate. It then expects the snapped new rate to take over at the next strobe. The second pair is an underrun and a fresh request from the same DAC pair. The bench withholds data_i bits on strobes that follow a request and expects both pulses together. Random mixes of writes, strobes, data gaps and mode changes are compared frame by frame against an accumulator model kept in the bench.

// File: rtl/vrate_pkg.sv
package vrate_pkg;
  localparam int RATE_W    = 16;
  localparam int NUM_RATES = 7;
  localparam int FRAME_HZ  = 48000;
  localparam int NUM_DAC   = 3;
  localparam int NUM_CH    = NUM_DAC + 1;
  localparam int CH_LFE    = 2;
  localparam int CH_ADC    = NUM_DAC;
  localparam logic [6:0] BASE_ADDR = 7'h2C;
  typedef logic [RATE_W-1:0] rate_t;
  // ascending; snapping relies on the order
  localparam int RATE_TAB [NUM_RATES] = '{8000, 11025, 16000, 22050, 32000, 44100, 48000};
endpackage

// File: rtl/vrate_snap.sv
module vrate_snap
  import vrate_pkg::*;
(
  input  rate_t raw_i,
  output rate_t snap_o
);
  logic [NUM_RATES-2:0] above;

  // thermometer of midpoint compares; an exact midpoint stays low
  for (genvar k = 0; k < NUM_RATES - 1; k++) begin : g_cmp
    localparam int MID = (RATE_TAB[k] + RATE_TAB[k+1]) / 2;
    assign above[k] = int'(raw_i) > MID;
  end

  always_comb begin
    snap_o = rate_t'(RATE_TAB[0]);
    for (int k = 0; k < NUM_RATES - 1; k++)
      if (above[k]) snap_o = rate_t'(RATE_TAB[k+1]);
  end
endmodule

// File: rtl/vrate_pacer.sv
module vrate_pacer #(
  parameter int FRAME_RATE = 48000,
  parameter int RATE_W     = 16,
  localparam int PHW       = $clog2(2 * FRAME_RATE)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              frame_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              hit_o,
  output logic [PHW-1:0]    phase_o
);
  logic [PHW-1:0] phase_q, sum;
  logic           over;

  assign sum     = phase_q + PHW'(rate_i);
  assign over    = sum >= PHW'(FRAME_RATE);
  assign hit_o   = en_i & frame_i & over;
  assign phase_o = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      phase_q <= '0;
    else if (!en_i)   phase_q <= '0;
    else if (frame_i) phase_q <= over ? sum - PHW'(FRAME_RATE) : sum;
  end
endmodule

// File: rtl/vrate_requester.sv
module vrate_requester
  import vrate_pkg::*;
#(
  parameter int FRAME_RATE = FRAME_HZ,
  parameter int ADDR_W     = 7,
  localparam int PHW       = $clog2(2 * FRAME_RATE)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_i,
  input  logic [1:0]         mode_i,
  input  logic [1:0]         id_i,
  input  logic [NUM_DAC-1:0] data_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [RATE_W-1:0]  wr_data_i,
  output logic [RATE_W-1:0]  rd_data_o,
  output logic [NUM_DAC-1:0] req_o,
  output logic               adc_valid_o,
  output logic [NUM_DAC-1:0] underrun_o
);
  logic                           lfe_act;
  logic [NUM_CH-1:0]              ch_en, sel, hit_w, req_q;
  logic [NUM_CH-1:0][RATE_W-1:0]  rate_q;
  logic [NUM_CH-1:0][PHW-1:0]     phase_w;
  logic [NUM_DAC-1:0]             pend_q, und_q;
  rate_t                          snapped;

  assign lfe_act = (mode_i == 2'b10) && (id_i == 2'b11);

  always_comb begin
    ch_en         = '1;
    ch_en[CH_LFE] = lfe_act;
  end

  vrate_snap u_snap (.raw_i(wr_data_i), .snap_o(snapped));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] CH_ADDR = ADDR_W'(BASE_ADDR) + ADDR_W'(2 * i);
    assign sel[i] = (addr_i == CH_ADDR) && ch_en[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                rate_q[i] <= RATE_W'(RATE_TAB[NUM_RATES-1]);
      else if (wr_en_i && sel[i]) rate_q[i] <= snapped;
    end

    vrate_pacer #(.FRAME_RATE(FRAME_RATE), .RATE_W(RATE_W)) u_pacer (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (ch_en[i]),
      .frame_i(frame_i),
      .rate_i (rate_q[i]),
      .hit_o  (hit_w[i]),
      .phase_o(phase_w[i])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) req_q[i] <= 1'b0;
      else         req_q[i] <= hit_w[i];
    end

    if (i < NUM_DAC) begin : g_und
      // request outstanding from the last strobe; data due on this one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          pend_q[i] <= 1'b0;
          und_q[i]  <= 1'b0;
        end else if (!ch_en[i]) begin
          pend_q[i] <= 1'b0;
          und_q[i]  <= 1'b0;
        end else begin
          und_q[i] <= frame_i && pend_q[i] && !data_i[i];
          if (frame_i) pend_q[i] <= hit_w[i];
        end
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (sel[i]) rd_data_o = rate_q[i];
  end

  assign req_o       = req_q[NUM_DAC-1:0];
  assign adc_valid_o = req_q[CH_ADC];
  assign underrun_o  = und_q;
endmodule

// File: rtl/vrate_requester_chk.sv
module vrate_requester_chk
  import vrate_pkg::*;
#(
  parameter int PHW = $clog2(2 * FRAME_HZ)
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          frame_i,
  input logic [1:0]                    mode_i,
  input logic [1:0]                    id_i,
  input logic [NUM_DAC-1:0]            data_i,
  input logic [NUM_DAC-1:0]            req_o,
  input logic                          adc_valid_o,
  input logic [NUM_DAC-1:0]            underrun_o,
  input logic [NUM_CH-1:0][RATE_W-1:0] rate_q,
  input logic [NUM_CH-1:0][PHW-1:0]    phase_w
);
  function automatic logic legal(input logic [RATE_W-1:0] r);
    legal = 1'b0;
    for (int k = 0; k < NUM_RATES; k++)
      if (int'(r) == RATE_TAB[k]) legal = 1'b1;
  endfunction

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    AST_RATE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      legal(rate_q[i])); // R3
    AST_PHASE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(phase_w[i]) < FRAME_HZ); // R4
  end

  for (genvar i = 0; i < NUM_DAC; i++) begin : g_dac
    AST_UNDERRUN_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      underrun_o[i] |-> $past(frame_i && !data_i[i])); // R8
  end

  AST_FULL_RATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && int'(rate_q[0]) == FRAME_HZ) |=> req_o[0]); // R4
  AST_LFE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o[CH_LFE] |-> $past(mode_i == 2'b10 && id_i == 2'b11)); // R7
  AST_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|{req_o, adc_valid_o, underrun_o}) |-> $past(frame_i)); // R10
endmodule

bind vrate_requester vrate_requester_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .frame_i    (frame_i),
  .mode_i     (mode_i),
  .id_i       (id_i),
  .data_i     (data_i),
  .req_o      (req_o),
  .adc_valid_o(adc_valid_o),
  .underrun_o (underrun_o),
  .rate_q     (rate_q),
  .phase_w    (phase_w)
);

// File: tb/vrate_requester_tb_top.sv
module vrate_requester_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        frame_i = 1'b0;
  logic [1:0]  mode_i = 2'b00, id_i = 2'b00;
  logic [2:0]  data_i = 3'b000;
  logic        wr_en_i = 1'b0;
  logic [6:0]  addr_i = 7'h00;
  logic [15:0] wr_data_i = 16'h0;
  logic [15:0] rd_data_o;
  logic [2:0]  req_o, underrun_o;
  logic        adc_valid_o;

  int checks = 0, fails = 0;
  int m_rate [4];
  int m_ph   [4];
  bit m_pend [3];
  bit m_lfe;
  int n_front, n_adc;

  always #4 clk = ~clk;

  vrate_requester dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .frame_i(frame_i), .mode_i(mode_i), .id_i(id_i),
    .data_i(data_i), .wr_en_i(wr_en_i), .addr_i(addr_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o), .req_o(req_o), .adc_valid_o(adc_valid_o), .underrun_o(underrun_o)
  );

  function automatic int snap_ref(input int v);
    int tab [7] = '{8000, 11025, 16000, 22050, 32000, 44100, 48000};
    int best = tab[0];
    int bd = (v > tab[0]) ? v - tab[0] : tab[0] - v;
    for (int k = 1; k < 7; k++) begin
      int d = (v > tab[k]) ? v - tab[k] : tab[k] - v;
      if (d < bd) begin bd = d; best = tab[k]; end
    end
    return best;
  endfunction

  function automatic int ch_of(input logic [6:0] a);
    case (a)
      7'h2C: return 0;
      7'h2E: return 1;
      7'h30: return m_lfe ? 2 : -1;
      7'h32: return 3;
      default: return -1;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_write(input logic [6:0] a, input int v);
    int c = ch_of(a);
    if (c >= 0) m_rate[c] = snap_ref(v);
  endtask

  task automatic wr(input logic [6:0] a, input int v);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wr_data_i = 16'(v);
    model_write(a, v);
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd_chk(input logic [6:0] a, input int exp, input string tag);
    @(negedge clk);
    addr_i = a;
    #1;
    chk(int'(rd_data_o) == exp, tag, int'(rd_data_o), exp);
  endtask

  task automatic set_mode(input logic [1:0] m, input logic [1:0] id);
    @(negedge clk);
    mode_i = m; id_i = id;
    m_lfe = (m == 2'b10) && (id == 2'b11);
    if (!m_lfe) begin m_ph[2] = 0; m_pend[2] = 0; end
    @(negedge clk);
  endtask

  // strobe one frame; optional write in the same cycle (R9)
  task automatic frame(input logic [2:0] d, input bit w, input logic [6:0] a, input int v);
    bit er [4];
    bit eu [3];
    @(negedge clk);
    frame_i = 1'b1; data_i = d;
    if (w) begin wr_en_i = 1'b1; addr_i = a; wr_data_i = 16'(v); end
    for (int c = 0; c < 4; c++) begin
      bit en = (c != 2) || m_lfe;
      er[c] = 1'b0;
      if (en) begin
        int s = m_ph[c] + m_rate[c];
        er[c] = s >= 48000;
        m_ph[c] = er[c] ? s - 48000 : s;
      end
      if (c < 3) begin
        eu[c] = en && m_pend[c] && !d[c];
        m_pend[c] = er[c];
      end
    end
    if (w) model_write(a, v);
    @(negedge clk);
    frame_i = 1'b0; wr_en_i = 1'b0;
    chk(req_o == {er[2], er[1], er[0]}, "R4 req_o", int'(req_o), int'({er[2], er[1], er[0]}));
    chk(adc_valid_o == er[3], "R6 adc_valid_o", int'(adc_valid_o), int'(er[3]));
    chk(underrun_o == {eu[2], eu[1], eu[0]}, "R8 underrun_o", int'(underrun_o),
        int'({eu[2], eu[1], eu[0]}));
    if (req_o[0]) n_front++;
    if (adc_valid_o) n_adc++;
    @(negedge clk);
    chk({req_o, adc_valid_o, underrun_o} == 7'd0, "R10 quiet", int'({req_o, adc_valid_o, underrun_o}), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    for (int c = 0; c < 4; c++) begin m_rate[c] = 48000; m_ph[c] = 0; end
    for (int c = 0; c < 3; c++) m_pend[c] = 0;
    m_lfe = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 / R2 reset and map
    rd_chk(7'h2C, 48000, "R1 front");
    rd_chk(7'h2E, 48000, "R1 rear");
    rd_chk(7'h32, 48000, "R1 adc");
    rd_chk(7'h30, 0, "R7 lfe hidden");
    rd_chk(7'h2A, 0, "R2 unmapped");
    wr(7'h34, 8000);
    rd_chk(7'h34, 0, "R2 unmapped write");
    rd_chk(7'h2C, 48000, "R2 unmapped write no side effect");
    wr(7'h30, 8000);
    set_mode(2'b10, 2'b11);
    rd_chk(7'h30, 48000, "R1 lfe / R7 write ignored");

    // R5 / R6 long run from phase 0
    wr(7'h2C, 44100);
    wr(7'h32, 8000);
    n_front = 0; n_adc = 0;
    for (int f = 0; f < 480; f++) frame(3'b111, 0, 7'h0, 0);
    chk(n_front == 441, "R5 front count", n_front, 441);
    chk(n_adc == 80, "R6 adc count", n_adc, 80);

    // R3 snapping corners
    wr(7'h2E, 19025); rd_chk(7'h2E, 16000, "R3 tie low");
    wr(7'h2E, 19026); rd_chk(7'h2E, 22050, "R3 above tie");
    wr(7'h2E, 9512);  rd_chk(7'h2E, 8000,  "R3 9512");
    wr(7'h2E, 9513);  rd_chk(7'h2E, 11025, "R3 9513");
    wr(7'h2E, 0);     rd_chk(7'h2E, 8000,  "R3 zero");
    wr(7'h2E, 65535); rd_chk(7'h2E, 48000, "R3 max");
    wr(7'h2E, 46050); rd_chk(7'h2E, 44100, "R3 46050");
    wr(7'h2E, 24000); rd_chk(7'h2E, 22050, "R3 24000");

    // R8 underrun alongside a new request (rear 48000 fires every frame)
    wr(7'h2E, 48000);
    frame(3'b111, 0, 7'h0, 0);
    frame(3'b101, 0, 7'h0, 0);
    frame(3'b000, 0, 7'h0, 0);

    // R9 write in a strobe cycle
    frame(3'b111, 1, 7'h2E, 8000);
    frame(3'b111, 0, 7'h0, 0);
    rd_chk(7'h2E, 8000, "R9 new rate stored");

    // R7 disable clears lfe
    set_mode(2'b00, 2'b11);
    rd_chk(7'h30, 0, "R7 read disabled");
    frame(3'b000, 0, 7'h0, 0);

    // random mix
    for (int it = 0; it < 600; it++) begin
      int op = $urandom_range(0, 9);
      logic [6:0] a = 7'h2C + 7'($urandom_range(0, 3) * 2);
      int v = (op == 9) ? $urandom_range(0, 65535) : $urandom_range(7000, 50000);
      if (op < 6) frame(3'($urandom_range(0, 7)), 0, 7'h0, 0);
      else if (op < 8) frame(3'($urandom_range(0, 7)), 1, a, v);
      else if (op == 8) set_mode(2'($urandom_range(0, 3)), 2'($urandom_range(2, 3)));
      else begin wr(a, v); rd_chk(a, (ch_of(a) >= 0) ? m_rate[ch_of(a)] : 0, "R3 random"); end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule